// File: doc/BRIEF.md
# Monotonic multi-stream wall clock

This block keeps one wide wall-clock register that several audio streams share. A caller asks to move the clock to a target value. Without force, the move goes ahead only if every active stream has already reached that target. The value stored is then the largest of the target and the positions of the active streams. A forced request skips the stream check and stores the target exactly.

Each request gets an acknowledge one cycle after it is taken. The acknowledge says whether the register now holds exactly the requested value. When it does not, the caller knows the update was delayed or adjusted.

A non-forced request never moves the register backwards. The block also watches for repeated non-forced writes that leave the value unchanged, which point to a stalled stream, and raises a warning when they pile up.

Top module: `mswc_top`

## Requirements
- R1: After reset, `wall_value` is 0, `ack_valid` is 0, `ack_exact` is 0 and `stale_warn` is 0.
- R2: A non-forced request is refused while any active stream's position is below the target; the register then keeps its value.
- R3: An accepted non-forced request stores the maximum of the target and all active stream positions.
- R4: A stream whose bit in `strm_active` (bit i belongs to stream i) is 0 takes no part in the gate check or in the maximum.
- R5: A forced request stores the target unchanged, whatever the streams report and even if the value goes down.
- R6: A non-forced request whose computed value is below the current register leaves the register unchanged, so non-forced requests never decrease it.
- R7: `ack_valid` is high for exactly the one cycle after each clock edge that samples `req_valid` high. In that cycle `ack_exact` is 1 only if `wall_value` equals that request's target.
- R8: Each accepted non-forced write that equals the current value adds one to a stale count. `stale_warn` is high while the count exceeds STALE_LIMIT (default 3), so it rises on the fourth such write in a row. Any write that changes the value clears the count.
- R9: The register changes only on a clock edge that samples a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request strobe, one cycle per request |
| req_force | input | 1 | Store the target without the stream gate |
| req_target | input | WIDTH | Requested wall-clock value |
| strm_active | input | NUM_STREAMS | Active flag per stream |
| strm_pos | input | NUM_STREAMS*WIDTH | Elapsed positions, stream i at bits [i*WIDTH +: WIDTH] |
| wall_value | output | WIDTH | Current wall-clock register |
| ack_valid | output | 1 | Acknowledge strobe, one cycle after a request |
| ack_exact | output | 1 | Register equals the requested target |
| stale_warn | output | 1 | Too many unchanged non-forced writes in a row |

## Verification
A request sampled at one rising edge updates `wall_value`, `ack_valid`, `ack_exact` and the stale count at that same edge, so all results can be seen one edge after the stimulus. The bench drives inputs on the falling edge. It updates a behavioural model with the same request, waits for the next rising edge, and compares all four outputs with the model on the falling edge after it. The cycle with no request that follows confirms that the acknowledge lasts one cycle and that the register holds its value.

// File: rtl/mswc_pkg.sv
package mswc_pkg;
   function automatic int unsigned cnt_bits(input int unsigned limit);
      return $clog2(limit + 2);
   endfunction
endpackage

// File: rtl/mswc_gate.sv
module mswc_gate #(
   parameter int unsigned WIDTH       = 64,
   parameter int unsigned NUM_STREAMS = 3
) (
   input  logic [WIDTH-1:0]             target,
   input  logic [NUM_STREAMS-1:0]       active,
   input  logic [NUM_STREAMS*WIDTH-1:0] pos,
   output logic                         all_passed,
   output logic [WIDTH-1:0]             max_val
);
   logic [WIDTH-1:0]       chain [NUM_STREAMS+1];
   logic [NUM_STREAMS-1:0] passed;

   assign chain[0] = target;

   generate
      for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_strm
         logic [WIDTH-1:0] p;
         assign p         = pos[i*WIDTH +: WIDTH];
         assign passed[i] = !active[i] || (p >= target);
         assign chain[i+1] = (active[i] && (p > chain[i])) ? p : chain[i];
      end
   endgenerate

   assign all_passed = &passed;
   assign max_val    = chain[NUM_STREAMS];

   always_comb begin
      a_max_not_below_target_r3 : assert (max_val >= target);
   end
endmodule

// File: rtl/mswc_stale.sv
module mswc_stale #(
   parameter int unsigned STALE_LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stale_evt,
   input  logic change_evt,
   output logic warn
);
   localparam int unsigned CW  = mswc_pkg::cnt_bits(STALE_LIMIT);
   localparam int unsigned SAT = STALE_LIMIT + 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                   cnt <= '0;
      else if (change_evt)          cnt <= '0;
      else if (stale_evt && (cnt != CW'(SAT))) cnt <= cnt + 1'b1;
   end

   assign warn = (cnt > CW'(STALE_LIMIT));

   p_warn_needs_stale_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(warn) |-> $past(stale_evt));
   p_change_clears_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      change_evt |=> !warn);
endmodule

// File: rtl/mswc_top.sv
module mswc_top #(
   parameter int unsigned WIDTH       = 64,
   parameter int unsigned NUM_STREAMS = 3,
   parameter int unsigned STALE_LIMIT = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic                         req_force,
   input  logic [WIDTH-1:0]             req_target,
   input  logic [NUM_STREAMS-1:0]       strm_active,
   input  logic [NUM_STREAMS*WIDTH-1:0] strm_pos,
   output logic [WIDTH-1:0]             wall_value,
   output logic                         ack_valid,
   output logic                         ack_exact,
   output logic                         stale_warn
);
   generate
      if (WIDTH < 2)       begin : g_bad_width  $error("WIDTH must be at least 2"); end
      if (NUM_STREAMS < 1) begin : g_bad_streams $error("NUM_STREAMS must be at least 1"); end
      if (STALE_LIMIT < 1) begin : g_bad_limit  $error("STALE_LIMIT must be at least 1"); end
   endgenerate

   logic             all_passed;
   logic [WIDTH-1:0] max_val;
   logic             accept_nf;
   logic             do_write;
   logic [WIDTH-1:0] nxt_val;
   logic [WIDTH-1:0] after_val;
   logic             stale_evt;
   logic             change_evt;

   mswc_gate #(.WIDTH(WIDTH), .NUM_STREAMS(NUM_STREAMS)) u_gate (
      .target     (req_target),
      .active     (strm_active),
      .pos        (strm_pos),
      .all_passed (all_passed),
      .max_val    (max_val)
   );

   assign accept_nf  = req_valid && !req_force && all_passed && (max_val >= wall_value);
   assign do_write   = (req_valid && req_force) || accept_nf;
   assign nxt_val    = req_force ? req_target : max_val;
   assign after_val  = do_write ? nxt_val : wall_value;
   assign stale_evt  = accept_nf && (max_val == wall_value);
   assign change_evt = do_write && (nxt_val != wall_value);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wall_value <= '0;
         ack_valid  <= 1'b0;
         ack_exact  <= 1'b0;
      end else begin
         if (do_write) wall_value <= nxt_val;
         ack_valid <= req_valid;
         ack_exact <= req_valid && (after_val == req_target);
      end
   end

   mswc_stale #(.STALE_LIMIT(STALE_LIMIT)) u_stale (
      .clk        (clk),
      .rst_n      (rst_n),
      .stale_evt  (stale_evt),
      .change_evt (change_evt),
      .warn       (stale_warn)
   );

   p_gate_holds_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_force && !all_passed) |=> $stable(wall_value));
   p_force_exact_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_force) |=> (wall_value == $past(req_target)));
   p_no_backstep_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_force) |=> (wall_value >= $past(wall_value)));
   p_ack_follows_req_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ack_valid);
   p_ack_only_after_req_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !ack_valid);
   p_ack_meaning_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (ack_exact == (wall_value == $past(req_target))));
   p_idle_stable_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(wall_value));
endmodule

// File: tb/sim_mswc_top.sv
module sim_mswc_top;
   localparam int W  = 64;
   localparam int NS = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_force = 1'b0;
   logic [W-1:0]  req_target = '0;
   logic [NS-1:0] strm_active = '0;
   logic [W-1:0]  p0 = '0, p1 = '0, p2 = '0;
   logic [W-1:0]  wall_value;
   logic          ack_valid, ack_exact, stale_warn;

   logic [W-1:0]  m_wall = '0;
   logic          m_done = 1'b0, m_ok = 1'b0;
   int            m_cnt = 0;
   int            checks = 0, errors = 0;
   bit            finished = 1'b0;

   always #5 clk = ~clk;

   mswc_top #(.WIDTH(W), .NUM_STREAMS(NS), .STALE_LIMIT(3)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_force(req_force),
      .req_target(req_target), .strm_active(strm_active), .strm_pos({p2, p1, p0}),
      .wall_value(wall_value), .ack_valid(ack_valid), .ack_exact(ack_exact),
      .stale_warn(stale_warn)
   );

   task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "wall_value", wall_value, m_wall);
      chk(tag, "ack_valid", W'(ack_valid), W'(m_done));
      chk(tag, "ack_exact", W'(ack_exact), W'(m_ok));
      chk(tag, "stale_warn", W'(stale_warn), W'(m_cnt > 3));
   endtask

   // one request (or idle) per cycle; model advanced behaviourally
   task automatic step(input string tag, input bit v, input bit f, input logic [W-1:0] t,
                       input logic [NS-1:0] a, input logic [W-1:0] q0,
                       input logic [W-1:0] q1, input logic [W-1:0] q2);
      logic [W-1:0] ps [NS];
      logic [W-1:0] best, nv;
      bit ok_all, wr;
      req_valid = v; req_force = f; req_target = t; strm_active = a;
      p0 = q0; p1 = q1; p2 = q2;
      ps[0] = q0; ps[1] = q1; ps[2] = q2;
      nv = m_wall; wr = 1'b0;
      if (v) begin
         if (f) begin
            nv = t; wr = 1'b1;
         end else begin
            ok_all = 1'b1; best = t;
            for (int i = 0; i < NS; i++) begin
               if (a[i]) begin
                  if (ps[i] < t) ok_all = 1'b0;
                  if (ps[i] > best) best = ps[i];
               end
            end
            if (ok_all && best >= m_wall) begin
               nv = best; wr = 1'b1;
               if (best == m_wall && m_cnt < 4) m_cnt++;
            end
         end
         if (wr && nv != m_wall) m_cnt = 0;
      end
      m_done = v;
      m_ok   = v && (nv == t);
      m_wall = nv;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      step("R5", 1, 1, 64'd100, 3'b000, 0, 0, 0);
      step("R3", 1, 0, 64'd150, 3'b111, 64'd160, 64'd170, 64'd155);
      step("R2", 1, 0, 64'd200, 3'b111, 64'd210, 64'd190, 64'd300);
      step("R4", 1, 0, 64'd200, 3'b001, 64'd210, 64'd190, 64'd300);
      step("R9", 0, 0, 64'd999, 3'b111, 64'd999, 64'd999, 64'd999);
      step("R8", 1, 0, 64'd210, 3'b001, 64'd210, 0, 0);
      step("R8", 1, 0, 64'd210, 3'b001, 64'd210, 0, 0);
      step("R8", 1, 0, 64'd210, 3'b001, 64'd210, 0, 0);
      step("R8", 1, 0, 64'd210, 3'b001, 64'd210, 0, 0);
      step("R8", 1, 0, 64'd210, 3'b001, 64'd210, 0, 0);
      step("R5", 1, 1, 64'd50, 3'b111, 0, 0, 0);
      step("R6", 1, 0, 64'd40, 3'b000, 0, 0, 0);
      step("R7", 0, 0, 0, 3'b000, 0, 0, 0);
      step("R7", 1, 0, 64'd80, 3'b000, 64'd5, 64'd5, 64'd5);
      step("R2", 1, 0, 64'd90, 3'b110, 64'd500, 64'd89, 64'd95);
      step("R5", 1, 1, 64'hFFFF_FFFF_0000_0000, 3'b000, 0, 0, 0);
      step("R3", 1, 0, 64'hFFFF_FFFF_0000_0001, 3'b101,
           64'hFFFF_FFFF_0000_0010, 0, 64'hFFFF_FFFF_FFFF_FFFF);
      step("R9", 0, 1, 64'd1, 3'b000, 0, 0, 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule